// File: doc/BRIEF.md
# NAND Ready/Status Wait Unit

This block sits beside a NAND flash command sequencer and decides when a device operation has finished. After the sequencer has sent a program, erase or read command it pulses `start_i`. The unit always waits a fixed write-to-busy delay first. It then watches one of two completion sources. The first is the device's active-high ready/busy pin, which passes through a synchronizer. The second is the ready bit of the status byte. For that source the unit asks the sequencer to send one STATUS command and then requests status bytes until the bit is seen.

A timeout bounds every wait. It is given in milliseconds, and a clock prescaler turns it into cycles. A value of zero picks the default for the chosen source: a longer one for the pin and a shorter one for status polling. When the timeout runs out, the unit does not report a failure at once. It takes one more sample of the ready source and flags a timeout only if the device is still busy at that sample. When the caller asks for it, the unit ends every wait with a fresh STATUS command and one byte read, and it returns that byte whether or not the wait timed out.

Requests to the sequencer form a valid/ready stream. `cmd_valid_o` and `cmd_op_o` stay unchanged until `cmd_ready_i` accepts them. Returned bytes arrive on a second valid/ready stream. The unit raises `rsp_ready_o` only while it expects a byte, so a producer may hold a byte back for any number of cycles.

Top module: `nand_wait_unit`

## Requirements
- R1: A start pulse is taken only while `busy_o` is low. `busy_o` is high from the cycle after an accepted start up to and including the `done_o` cycle. A start that arrives while busy changes neither the mode, the timeout nor the outcome.
- R2: No command request, pin sample or done pulse occurs within `TWB_CYCLES` cycles of an accepted start. If the pin is already high, `done_o` is seen exactly `TWB_CYCLES`+1 cycles after the start edge.
- R3: Pin mode (`mode_status_i`=0) samples `rdy_pin_i` through `SYNC_STAGES` flops. A pin that rises after the delay ends the wait with `done_o` `SYNC_STAGES`+1 cycles after the rise.
- R4: Status mode (`mode_status_i`=1) issues exactly one STATUS command (`cmd_op_o`=0). It then issues byte reads (`cmd_op_o`=1) until a returned byte ANDed with `READY_MASK` (default 8'h40, bit 6) is nonzero.
- R5: The timeout window is `timeout_ms_i` × `CLKS_PER_MS` cycles, counted from the end of the delay. A value of 0 selects `DEF_PIN_MS` (400) in pin mode and `DEF_STAT_MS` (250) in status mode. A timed-out wait never ends before the delay plus the window.
- R6: After the window expires, the ready source is sampled once more: one pin sample, or one more byte read. `timeout_o` is set only if that sample is still not ready.
- R7: With `want_final_i`=1, every wait ends with one STATUS command and one byte read, whatever the outcome. `status_o` then holds that byte.
- R8: A request held without `cmd_ready_i` keeps `cmd_valid_o` and `cmd_op_o` stable. `rsp_ready_o` is high only while a byte is awaited, and never while a request is pending.
- R9: `done_o` is a one-cycle pulse. `timeout_o` and `status_o` are cleared by an accepted start and then hold until the next accepted start; `status_o` takes every byte the unit accepts. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a wait (pulse) |
| mode_status_i | input | 1 | 0: ready pin, 1: status polling |
| timeout_ms_i | input | MS_W | Timeout in ms; 0 selects the mode default |
| want_final_i | input | 1 | Read a closing status byte at the end |
| rdy_pin_i | input | 1 | Device ready/busy pin, high = ready (asynchronous) |
| cmd_valid_o | output | 1 | Request to the sequencer is pending |
| cmd_ready_i | input | 1 | Sequencer accepts the request |
| cmd_op_o | output | 1 | 0: send STATUS command, 1: read one byte |
| rsp_valid_i | input | 1 | Returned byte is valid |
| rsp_ready_o | output | 1 | Unit accepts a returned byte |
| rsp_data_i | input | 8 | Returned status byte |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | Wait finished (one-cycle pulse) |
| timeout_o | output | 1 | Last wait timed out |
| status_o | output | 8 | Last status byte accepted |

## Verification
Two events can meet in one decision: the timeout window expires, and the ready source reports ready on its last sample. The bench sets this up in status mode. The responder returns busy bytes until just after the window ends, then answers the first read issued after expiry with a ready byte. The bench then expects `timeout_o` low and a finish time no earlier than the window. A second case keeps the device busy through that extra read and expects the flag set. Back-pressured request streams and a start issued in the middle of a wait are mixed into the same runs, to show that neither changes the outcome.

// File: rtl/nwu_pkg.sv
package nwu_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_TWB,
    S_PIN,
    S_PIN_LAST,
    S_SCMD,
    S_SRD,
    S_SRSP,
    S_FCMD,
    S_FRD,
    S_FRSP,
    S_DONE
  } wait_state_t;

  localparam logic OP_STATUS_CMD = 1'b0;
  localparam logic OP_READ_BYTE  = 1'b1;
endpackage

// File: rtl/nwu_sync.sv
module nwu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/nwu_ms_tick.sv
module nwu_ms_tick #(
  parameter int CLKS_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PRE_W = (CLKS_PER_MS > 2) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_MS - 1);

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear_i) cnt <= '0;
    else if (en_i) begin
      if (cnt == LAST) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign tick_o = en_i && !clear_i && (cnt == LAST);
endmodule

// File: rtl/nwu_timeout.sv
module nwu_timeout #(
  parameter int MS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic [MS_W-1:0] limit_i,
  input  logic            tick_i,
  output logic            expired_o
);
  logic [MS_W-1:0] ms_cnt;
  logic [MS_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt <= '0;
      lim_q  <= '1;
    end else if (arm_i) begin
      ms_cnt <= '0;
      lim_q  <= limit_i;
    end else if (tick_i && !expired_o) begin
      ms_cnt <= ms_cnt + 1'b1;
    end
  end

  assign expired_o = (ms_cnt >= lim_q);
endmodule

// File: rtl/nand_wait_unit.sv
module nand_wait_unit
  import nwu_pkg::*;
#(
  parameter int          CLKS_PER_MS = 100000,
  parameter int          MS_W        = 16,
  parameter int          TWB_CYCLES  = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  READY_MASK  = 8'h40,
  parameter int          DEF_PIN_MS  = 400,
  parameter int          DEF_STAT_MS = 250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            mode_status_i,
  input  logic [MS_W-1:0] timeout_ms_i,
  input  logic            want_final_i,
  input  logic            rdy_pin_i,
  output logic            cmd_valid_o,
  input  logic            cmd_ready_i,
  output logic            cmd_op_o,
  input  logic            rsp_valid_i,
  output logic            rsp_ready_o,
  input  logic [7:0]      rsp_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            timeout_o,
  output logic [7:0]      status_o
);
  localparam int TWB_W = $clog2(TWB_CYCLES + 1);
  localparam logic [TWB_W-1:0] TWB_LAST = TWB_W'(TWB_CYCLES - 1);
  localparam logic [MS_W-1:0]  PIN_DEF  = MS_W'(DEF_PIN_MS);
  localparam logic [MS_W-1:0]  STAT_DEF = MS_W'(DEF_STAT_MS);

  wait_state_t     state;
  logic            mode_q;
  logic            fin_q;
  logic            last_q;
  logic [MS_W-1:0] lim_q;
  logic [TWB_W-1:0] twb_cnt;

  logic rdy_s;
  logic tick;
  logic expired;
  logic arm;
  logic cmd_fire;
  logic rsp_fire;
  logic byte_ready;
  logic accept;
  logic [MS_W-1:0] lim_sel;

  nwu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rdy_pin_i),
    .q_o   (rdy_s)
  );

  nwu_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (busy_o),
    .clear_i (arm),
    .tick_o  (tick)
  );

  nwu_timeout #(.MS_W(MS_W)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .limit_i   (lim_q),
    .tick_i    (tick),
    .expired_o (expired)
  );

  always_comb begin
    if (timeout_ms_i != '0) lim_sel = timeout_ms_i;
    else if (mode_status_i) lim_sel = STAT_DEF;
    else lim_sel = PIN_DEF;
  end

  assign busy_o      = (state != S_IDLE);
  assign done_o      = (state == S_DONE);
  assign accept      = start_i && (state == S_IDLE);
  assign arm         = (state == S_TWB) && (twb_cnt == TWB_LAST);
  assign cmd_valid_o = (state == S_SCMD) || (state == S_SRD) ||
                       (state == S_FCMD) || (state == S_FRD);
  assign cmd_op_o    = ((state == S_SRD) || (state == S_FRD)) ? OP_READ_BYTE
                                                              : OP_STATUS_CMD;
  assign rsp_ready_o = (state == S_SRSP) || (state == S_FRSP);
  assign cmd_fire    = cmd_valid_o && cmd_ready_i;
  assign rsp_fire    = rsp_ready_o && rsp_valid_i;
  assign byte_ready  = |(rsp_data_i & READY_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mode_q    <= 1'b0;
      fin_q     <= 1'b0;
      last_q    <= 1'b0;
      lim_q     <= '0;
      twb_cnt   <= '0;
      timeout_o <= 1'b0;
      status_o  <= '0;
    end else begin
      if (rsp_fire) status_o <= rsp_data_i;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            state     <= S_TWB;
            mode_q    <= mode_status_i;
            fin_q     <= want_final_i;
            lim_q     <= lim_sel;
            last_q    <= 1'b0;
            twb_cnt   <= '0;
            timeout_o <= 1'b0;
            status_o  <= '0;
          end
        end
        S_TWB: begin
          if (twb_cnt == TWB_LAST) state <= mode_q ? S_SCMD : S_PIN;
          else twb_cnt <= twb_cnt + 1'b1;
        end
        S_PIN: begin
          if (rdy_s) state <= fin_q ? S_FCMD : S_DONE;
          else if (expired) state <= S_PIN_LAST;
        end
        S_PIN_LAST: begin
          timeout_o <= !rdy_s;
          state     <= fin_q ? S_FCMD : S_DONE;
        end
        S_SCMD: if (cmd_fire) state <= S_SRD;
        S_SRD:  if (cmd_fire) state <= S_SRSP;
        S_SRSP: begin
          if (rsp_fire) begin
            if (byte_ready) begin
              state <= fin_q ? S_FCMD : S_DONE;
            end else if (last_q) begin
              timeout_o <= 1'b1;
              state     <= fin_q ? S_FCMD : S_DONE;
            end else begin
              if (expired) last_q <= 1'b1;
              state <= S_SRD;
            end
          end
        end
        S_FCMD: if (cmd_fire) state <= S_FRD;
        S_FRD:  if (cmd_fire) state <= S_FRSP;
        S_FRSP: if (rsp_fire) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nwu_wait_chk.sv
module nwu_wait_chk #(
  parameter int TWB_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input logic [7:0] status_o,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic       cmd_op_o,
  input logic       rsp_ready_o
);
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (start_i && !busy_o) since <= '0;
    else if (since != 16'hFFFF) since <= since + 1'b1;
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  p_twb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || done_o) |-> (since >= 16'(TWB_CYCLES)));
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o)));
  p_one_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && rsp_ready_o));
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(timeout_o) && $stable(status_o)));
endmodule

bind nand_wait_unit nwu_wait_chk #(.TWB_CYCLES(TWB_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .status_o    (status_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_op_o    (cmd_op_o),
  .rsp_ready_o (rsp_ready_o)
);

// File: tb/nand_wait_unit_test.sv
module nand_wait_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPM   = 4;
  localparam int TWB   = 3;
  localparam int SYNC  = 2;
  localparam int NEVER = 100000;
  localparam logic [7:0] RDY_BYTE  = 8'hE0;
  localparam logic [7:0] BUSY_BYTE = 8'h80;

  typedef struct packed {
    logic        md;
    logic [15:0] tms;
    logic        fin;
    logic        bp;
    logic [31:0] rdy;
    logic        etmo;
    logic [7:0]  est;
    logic [31:0] escmd;
    logic [31:0] emin;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd5, 1'b0, 1'b0, 32'd10,    1'b0, 8'h00, 32'd0, 32'd10},
    '{1'b0, 16'd5, 1'b1, 1'b1, 32'd10,    1'b0, 8'hE0, 32'd1, 32'd10},
    '{1'b0, 16'd3, 1'b1, 1'b0, 32'd100000,1'b1, 8'h80, 32'd1, 32'd15},
    '{1'b1, 16'd5, 1'b0, 1'b0, 32'd15,    1'b0, 8'hE0, 32'd1, 32'd15},
    '{1'b1, 16'd3, 1'b1, 1'b1, 32'd100000,1'b1, 8'h80, 32'd2, 32'd15},
    '{1'b0, 16'd0, 1'b0, 1'b0, 32'd1500,  1'b0, 8'h00, 32'd0, 32'd1500},
    '{1'b1, 16'd0, 1'b1, 1'b0, 32'd900,   1'b0, 8'hE0, 32'd2, 32'd900},
    '{1'b0, 16'd0, 1'b0, 1'b0, 32'd100000,1'b1, 8'h00, 32'd0, 32'd1603},
    '{1'b1, 16'd0, 1'b0, 1'b0, 32'd100000,1'b1, 8'h80, 32'd1, 32'd1003},
    '{1'b1, 16'd3, 1'b0, 1'b0, 32'd17,    1'b0, 8'hE0, 32'd1, 32'd15}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [15:0] tmo_i = '0;
  logic fin_i = 1'b0;
  logic rdy_pin = 1'b0;
  logic cmd_valid, cmd_ready, cmd_op;
  logic rsp_valid;
  logic rsp_ready;
  logic [7:0] rsp_data;
  logic busy, done, tmo_flag;
  logic [7:0] status;

  logic bp_on = 1'b0;
  logic tgl;
  logic [31:0] rdy_at = 32'd100000;
  int unsigned cyc, scmd, ndone;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmd_ready = bp_on ? tgl : 1'b1;

  nand_wait_unit #(
    .CLKS_PER_MS(CPM), .MS_W(16), .TWB_CYCLES(TWB), .SYNC_STAGES(SYNC),
    .READY_MASK(8'h40), .DEF_PIN_MS(400), .DEF_STAT_MS(250)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_status_i(mode_i),
    .timeout_ms_i(tmo_i), .want_final_i(fin_i), .rdy_pin_i(rdy_pin),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data),
    .busy_o(busy), .done_o(done), .timeout_o(tmo_flag), .status_o(status)
  );

  // Device model: pin, status bytes, request counters.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; scmd <= 0; ndone <= 0; tgl <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= 8'h00; rdy_pin <= 1'b0;
    end else begin
      tgl <= ~tgl;
      if (start_i && !busy) begin
        cyc <= 0; scmd <= 0; ndone <= 0;
        rdy_pin <= (rdy_at == 0);
      end else begin
        cyc <= cyc + 1;
        rdy_pin <= ((cyc + 1) >= rdy_at);
        if (done) ndone <= ndone + 1;
        if (cmd_valid && cmd_ready && cmd_op == 1'b0) scmd <= scmd + 1;
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (cmd_valid && cmd_ready && cmd_op == 1'b1) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ((cyc + 1) >= rdy_at) ? RDY_BYTE : BUSY_BYTE;
      end
    end
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input logic [31:0] act, input logic [31:0] lo);
    checks++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s: actual %0d expected >= %0d", req, act, lo);
    end
  endtask

  task automatic pulse_start(input logic md, input logic [15:0] tms, input logic fn,
                             input logic bpv, input logic [31:0] ra);
    @(negedge clk);
    mode_i = md; tmo_i = tms; fin_i = fn; bp_on = bpv; rdy_at = ra; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int unsigned el);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual no done expected done");
    end
    el = cyc;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual run hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned el;
    logic t_hold;
    logic [7:0] s_hold;
    repeat (5) @(negedge clk);
    // R9: reset state
    check_eq("R9 busy after reset", busy, 0);
    check_eq("R9 done after reset", done, 0);
    check_eq("R9 timeout after reset", tmo_flag, 0);
    check_eq("R9 status after reset", status, 0);
    check_eq("R8 cmd_valid after reset", cmd_valid, 0);
    check_eq("R8 rsp_ready after reset", rsp_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pulse_start(VECS[i].md, VECS[i].tms, VECS[i].fin, VECS[i].bp, VECS[i].rdy);
      wait_done(el);
      check_eq("R6 timeout flag", tmo_flag, VECS[i].etmo);
      check_eq("R7 status byte", status, VECS[i].est);
      check_eq(VECS[i].bp ? "R8 status commands" : "R4 status commands", scmd, VECS[i].escmd);
      check_ge("R5 finish time", el, VECS[i].emin);
      t_hold = tmo_flag; s_hold = status;
      repeat (4) @(negedge clk);
      check_eq("R9 one done pulse", ndone, 1);
      check_eq("R9 timeout held", tmo_flag, t_hold);
      check_eq("R9 status held", status, s_hold);
      check_eq("R1 busy low after done", busy, 0);
    end

    // R2: pin already ready, done exactly after the write-to-busy delay
    pulse_start(1'b0, 16'd5, 1'b0, 1'b0, 32'd0);
    wait_done(el);
    check_eq("R2 done time with ready pin", el, TWB + 1);
    repeat (3) @(negedge clk);

    // R3: pin rises late; done after synchronizer stages plus one
    pulse_start(1'b0, 16'd10, 1'b0, 1'b0, 32'd20);
    wait_done(el);
    check_eq("R3 done time after pin rise", el, 20 + SYNC + 1);
    check_eq("R3 no timeout", tmo_flag, 0);
    repeat (3) @(negedge clk);

    // R1: a second start while busy is ignored
    pulse_start(1'b0, 16'd5, 1'b0, 1'b0, 32'd12);
    repeat (3) @(negedge clk);
    mode_i = 1'b1; tmo_i = 16'd1; fin_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check_eq("R1 busy kept during ignored start", busy, 1);
    wait_done(el);
    check_ge("R1 original pin wait kept", el, 12);
    check_eq("R1 no status traffic from ignored start", scmd, 0);
    check_eq("R1 no timeout from ignored start", tmo_flag, 0);
    repeat (4) @(negedge clk);
    check_eq("R1 single done pulse", ndone, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule